// File: doc/BRIEF.md
# Center-Aligned Up-Down PWM Timer

This block makes a symmetric (center-aligned) PWM waveform from one time-base counter. The counter climbs from zero to a programmed period, turns around, and falls back to zero. One full waveform period therefore lasts twice the period value in clock cycles. A single compare value places the output edges symmetrically about the peak. The output goes high when the rising ramp meets the compare value and goes low when the falling ramp meets it again. A compare of half the period gives a 50% duty cycle.

Period and compare are written through a small write port into shadow copies. The active values are replaced only when the running counter sits at zero, so a new setting never cuts a waveform period short. A one-cycle event pulse marks each peak, and a sticky flag holds it for an interrupt controller until it is cleared. A shared time-base enable freezes every instance while they are configured. When that enable rises, all instances begin counting on the same edge. Dead-band shaping is done by a separate block that follows this one.

Top module: `updown_pwm`

## Requirements
- R1: After reset the counter is 0, the direction output is 0 (up), and the PWM output, event pulse and event flag are all 0. Both shadow values and both active values are also 0.
- R2: With active period P ≥ 1 and the enable high, the counter goes 0,1,…,P,P−1,…,1,0 and repeats, so one waveform period is 2·P cycles. The direction output is 1 exactly while the last step was downward, which makes the peak part of the rising ramp.
- R3: A write with wr_sel = 0 loads the period shadow. The active period takes the shadow value on an enabled cycle in which the counter is 0, and that value also governs the step taken from that zero. A period write on that same cycle only takes effect at the following zero.
- R4: A write with wr_sel = 1 loads the compare shadow. It is transferred under the same zero-point rule as the period, including the deferral of a write that lands on the transfer cycle.
- R5: With active compare C and 1 ≤ C < P, the PWM output rises one cycle after the counter reaches C on the rising ramp. It falls one cycle after the counter reaches C on the falling ramp, which makes it high for 2·(P−C) cycles of each period. C = P/2 gives 50%.
- R6: A compare of 0, or a compare of P or more, never sets the output, so the output stays low for the whole period.
- R7: evt_pulse is high for exactly one cycle, the cycle in which the counter shows the peak P. evt_flag goes high with the pulse and stays high until evt_clr is seen. If a clear and a new pulse arrive on the same cycle, the flag is set.
- R8: While tb_en is low, the counter, the direction, the PWM output and the active values hold, and no event pulse is raised. Instances configured while tb_en is low count in lockstep once it rises.
- R9: A write with wr_sel = 2 loads the counter directly on the next edge, takes priority over counting, and sets the direction to up. Counting then continues: upward if the loaded value is below the active period, otherwise downward. wr_sel = 3 is ignored.
- R10: An active period of 0 holds the counter at 0, with no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_en | input | 1 | Global time-base enable shared by instances |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 period, 1 compare, 2 counter, 3 none |
| wr_data | input | CW | Write value |
| evt_clr | input | 1 | Clears the sticky event flag |
| tb_count | output | CW | Current counter value |
| tb_dir_down | output | 1 | 1 when the last step was downward |
| pwm_out | output | 1 | Raw PWM output |
| evt_pulse | output | 1 | One-cycle pulse at the period peak |
| evt_flag | output | 1 | Sticky period event flag |

## Verification
Two pairs of functions can meet on one clock edge. The first pair is a shadow write and the zero-point transfer. The second is an event-flag clear and a new peak pulse. The bench places a period write, and separately a compare write, on the exact sample where the counter reads zero. It then measures the peak, length and high time of the next two waveform periods: the first must still show the old value and the second the new one. It also asserts the clear on the sample just before the peak and requires both the pulse and the flag to be high on the next sample.

// File: rtl/updown_pwm.sv
module updown_pwm #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tb_en,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          evt_clr,
  output logic [CW-1:0] tb_count,
  output logic          tb_dir_down,
  output logic          pwm_out,
  output logic          evt_pulse,
  output logic          evt_flag
);

  logic [CW-1:0] prd_sh, cmp_sh, prd_act, cmp_act;

  wire at_zero = (tb_count == '0);
  wire [CW-1:0] prd_eff = at_zero ? prd_sh : prd_act;
  wire cnt_wr = wr_en && (wr_sel == 2'd2);
  wire hold = at_zero && (prd_eff == '0);
  wire go_up = at_zero || (!tb_dir_down && (tb_count < prd_eff));
  wire [CW-1:0] cnt_nx = hold ? '0 : (go_up ? tb_count + 1'b1 : tb_count - 1'b1);

  wire up_hit = !tb_dir_down && (tb_count == cmp_act) && (cmp_act != '0) && (cmp_act < prd_act);
  wire dn_hit = tb_dir_down && (tb_count == cmp_act);
  wire pulse_nx = tb_en && !cnt_wr && !hold && go_up && (cnt_nx == prd_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_sh      <= '0;
      cmp_sh      <= '0;
      prd_act     <= '0;
      cmp_act     <= '0;
      tb_count    <= '0;
      tb_dir_down <= 1'b0;
      pwm_out     <= 1'b0;
      evt_pulse   <= 1'b0;
      evt_flag    <= 1'b0;
    end else begin
      if (wr_en && wr_sel == 2'd0) prd_sh <= wr_data;
      if (wr_en && wr_sel == 2'd1) cmp_sh <= wr_data;
      evt_pulse <= pulse_nx;
      evt_flag  <= pulse_nx || (evt_flag && !evt_clr);
      if (cnt_wr) begin
        tb_count    <= wr_data;
        tb_dir_down <= 1'b0;
      end else if (tb_en) begin
        if (at_zero) begin
          prd_act <= prd_sh;
          cmp_act <= cmp_sh;
        end
        tb_count    <= cnt_nx;
        tb_dir_down <= !hold && !go_up;
        if (up_hit)      pwm_out <= 1'b1;
        else if (dn_hit) pwm_out <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/updown_pwm_chk.sv
module updown_pwm_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tb_en,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic          evt_clr,
  input logic [CW-1:0] tb_count,
  input logic          tb_dir_down,
  input logic          pwm_out,
  input logic          evt_pulse,
  input logic          evt_flag,
  input logic [CW-1:0] cmp_act
);

  wire cnt_wr = wr_en && (wr_sel == 2'd2);

  // R2
  step_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tb_en) && !$past(cnt_wr)) |->
      (tb_count == $past(tb_count) + 1'b1 || tb_count == $past(tb_count) - 1'b1 ||
       (tb_count == '0 && $past(tb_count) == '0)));

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tb_en) && !$past(cnt_wr)) |->
      ($stable(tb_count) && $stable(pwm_out) && !evt_pulse));

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |=> !evt_pulse);

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> evt_flag);

  // R7
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt_clr) && !evt_pulse) |-> !evt_flag);

  // R5
  rise_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> ($past(tb_count) == $past(cmp_act) && !$past(tb_dir_down)));

endmodule

bind updown_pwm updown_pwm_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .wr_en(wr_en), .wr_sel(wr_sel),
  .evt_clr(evt_clr), .tb_count(tb_count), .tb_dir_down(tb_dir_down),
  .pwm_out(pwm_out), .evt_pulse(evt_pulse), .evt_flag(evt_flag), .cmp_act(cmp_act)
);

// File: tb/sim_updown_pwm.sv
`timescale 1ns/1ps
module sim_updown_pwm;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tb_en = 1'b0;
  logic wr_en0 = 1'b0, wr_en1 = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [CW-1:0] wr_data = '0;
  logic evt_clr = 1'b0;
  logic [CW-1:0] cnt0, cnt1;
  logic dir0, dir1, pwm0, pwm1, pls0, pls1, flg0, flg1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  updown_pwm #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .wr_en(wr_en0), .wr_sel(wr_sel),
    .wr_data(wr_data), .evt_clr(evt_clr), .tb_count(cnt0), .tb_dir_down(dir0),
    .pwm_out(pwm0), .evt_pulse(pls0), .evt_flag(flg0));

  updown_pwm #(.CW(CW)) u1 (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .wr_en(wr_en1), .wr_sel(wr_sel),
    .wr_data(wr_data), .evt_clr(1'b0), .tb_count(cnt1), .tb_dir_down(dir1),
    .pwm_out(pwm1), .evt_pulse(pls1), .evt_flag(flg1));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr1(input logic [1:0] sel, input int d);
    wr_sel = sel; wr_data = CW'(d); wr_en0 = 1'b1;
    @(negedge clk);
    wr_en0 = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic wait_for(input int v, input logic d);
    while (!(cnt0 == CW'(v) && dir0 == d)) @(negedge clk);
  endtask

  task automatic wait_zero(output int pk, output int hi);
    pk = 0; hi = 0;
    while (cnt0 != '0) begin
      @(negedge clk);
      if (int'(cnt0) > pk) pk = int'(cnt0);
      hi += int'(pwm0);
    end
  endtask

  task automatic meas(input bit dowr, input logic [1:0] sel, input int d,
                      output int pk, output int ln, output int hi);
    pk = 0; ln = 0; hi = 0;
    if (dowr) begin wr_sel = sel; wr_data = CW'(d); wr_en0 = 1'b1; end
    do begin
      @(negedge clk);
      wr_en0 = 1'b0; wr_sel = 2'd3;
      ln++;
      if (int'(cnt0) > pk) pk = int'(cnt0);
      hi += int'(pwm0);
    end while (cnt0 != '0);
  endtask

  task automatic t_reset();
    check("R1 count", int'(cnt0), 0);
    check("R1 dir", int'(dir0), 0);
    check("R1 pwm", int'(pwm0), 0);
    check("R1 pulse/flag", int'(pls0) + int'(flg0), 0);
  endtask

  task automatic t_lockstep();
    int exp [10] = '{1, 2, 3, 4, 3, 2, 1, 0, 1, 2};
    int mism = 0, seqerr = 0;
    wr1(2'd0, 4);
    wr1(2'd1, 2);
    repeat (3) @(negedge clk);
    wr_sel = 2'd0; wr_data = 16'd4; wr_en1 = 1'b1; @(negedge clk);
    wr_sel = 2'd1; wr_data = 16'd2; @(negedge clk);
    wr_en1 = 1'b0; wr_sel = 2'd3;
    repeat (2) @(negedge clk);
    check("R8 frozen while disabled", int'(cnt0) + int'(cnt1), 0);
    tb_en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (cnt0 != cnt1) mism++;
      if (int'(cnt0) != exp[i]) seqerr++;
    end
    check("R8 lockstep mismatches", mism, 0);
    check("R2 first ramp errors", seqerr, 0);
    check("R7 flag after peak", int'(flg0), 1);
  endtask

  task automatic t_period();
    int pk, ln, hi;
    wait_zero(pk, hi);
    meas(1'b0, 2'd3, 0, pk, ln, hi);
    check("R2 peak", pk, 4);
    check("R2 length", ln, 8);
    check("R5 50% high time", hi, 4);
  endtask

  task automatic t_freeze();
    int c; logic p; int moved = 0;
    wait_for(3, 1'b0);
    tb_en = 1'b0;
    c = int'(cnt0); p = pwm0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (int'(cnt0) != c || pwm0 != p || pls0) moved++;
    end
    check("R8 hold while disabled", moved, 0);
    tb_en = 1'b1;
  endtask

  task automatic t_prd_shadow();
    int pk, ln, hi;
    wait_for(2, 1'b0);
    wr1(2'd0, 6);
    wait_zero(pk, hi);
    check("R3 old period kept mid-period", pk, 4);
    meas(1'b0, 2'd3, 0, pk, ln, hi);
    check("R3 new period at zero", pk, 6);
    check("R3 new length", ln, 12);
    check("R5 high time P6 C2", hi, 8);
    meas(1'b1, 2'd0, 4, pk, ln, hi);
    check("R3 same-cycle write deferred", pk, 6);
    meas(1'b0, 2'd3, 0, pk, ln, hi);
    check("R3 deferred write applied", pk, 4);
  endtask

  task automatic t_cmp_shadow();
    int pk, ln, hi;
    wait_for(1, 1'b0);
    wr1(2'd1, 3);
    wait_zero(pk, hi);
    check("R4 old compare kept mid-period", hi, 4);
    meas(1'b1, 2'd1, 1, pk, ln, hi);
    check("R4 compare 3 applied, same-cycle write deferred", hi, 2);
    meas(1'b1, 2'd1, 4, pk, ln, hi);
    check("R4 deferred compare 1 applied", hi, 6);
    meas(1'b1, 2'd1, 0, pk, ln, hi);
    check("R6 compare equal to period", hi, 0);
    meas(1'b1, 2'd1, 2, pk, ln, hi);
    check("R6 compare zero", hi, 0);
    meas(1'b0, 2'd3, 0, pk, ln, hi);
    check("R5 compare restored", hi, 4);
  endtask

  task automatic t_flag();
    wait_for(1, 1'b0);
    evt_clr = 1'b1;
    @(negedge clk);
    evt_clr = 1'b0;
    check("R7 flag cleared", int'(flg0), 0);
    wait_for(3, 1'b0);
    evt_clr = 1'b1;
    @(negedge clk);
    evt_clr = 1'b0;
    check("R7 pulse at peak", int'(pls0), 1);
    check("R7 set wins over clear", int'(flg0), 1);
    @(negedge clk);
    check("R7 pulse one cycle", int'(pls0), 0);
  endtask

  task automatic t_cnt_write();
    int pk, hi;
    wr1(2'd2, 3);
    check("R9 counter loaded", int'(cnt0), 3);
    check("R9 dir up after load", int'(dir0), 0);
    @(negedge clk);
    check("R9 counting resumes up", int'(cnt0), 4);
    wr1(2'd2, 9);
    check("R9 load above period", int'(cnt0), 9);
    @(negedge clk);
    check("R9 counts down from above period", int'(cnt0), 8);
    wr1(2'd3, 2);
    check("R9 wr_sel 3 ignored", int'(cnt0), 7);
    wait_zero(pk, hi);
  endtask

  task automatic t_zero_period();
    int pk, hi; int moved = 0;
    wr1(2'd0, 0);
    wait_zero(pk, hi);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (cnt0 != '0 || pls0) moved++;
    end
    check("R10 zero period holds", moved, 0);
    wr1(2'd0, 3);
    check("R10 still at zero on write edge", int'(cnt0), 0);
    @(negedge clk);
    check("R10 restart from shadow", int'(cnt0), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lockstep();
    t_period();
    t_freeze();
    t_prd_shadow();
    t_cmp_shadow();
    t_flag();
    t_cnt_write();
    t_zero_period();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule